// File: doc/BRIEF.md
# Digital Clock Frequency Corrector

This block trims the rate of a slow-clock prescaler so that a timekeeping counter stays accurate when its reference oscillator runs a little fast or slow. A signed correction value selects the direction and size of the trim. The block adjusts single prescaler cycles: either the prescaler skips one state, which removes a cycle, or it holds one state, which adds a cycle. Each adjustment is a one-cycle request issued in the cycle after a prescaler rollover pulse, so it always falls at prescaler phase zero. At most one adjustment is made per prescaler period.

The block groups prescaler periods into windows of 976. A window with magnitude m makes exactly m adjustments, and these are spread evenly by an accumulator that adds m once per period and fires each time it crosses 976. With 1024-cycle periods this gives a step of 1/999424 of the clock, which is about 1 ppm. The correction value is sampled only at the boundary between windows. A change made in the middle of a window therefore never splits it. The current period index within the window is brought out for observation.

Top module: `freq_trim_corrector`

## Requirements
- R1: After reset, `step_double` and `step_hold` are 0 and `win_idx` is 0. The correction applied in the first window is zero.
- R2: `win_idx` advances by one in the cycle after each `roll_pulse` and wraps from 975 to 0. Without a pulse it holds its value.
- R3: An adjustment request is high for exactly one cycle, and only in the cycle directly after a `roll_pulse`.
- R4: `step_double` and `step_hold` are never high in the same cycle.
- R5: A positive applied value gives only `step_double` requests, which make the prescaler advance by 2 and run faster. A negative value gives only `step_hold` requests, which make it advance by 0 and run slower.
- R6: With applied magnitude m, the pulse at window index k (counted 0 to 975) gives a request exactly when floor((k+1)·m/976) > floor(k·m/976). Each window therefore makes exactly m requests.
- R7: `corr_val` is sampled only on the `roll_pulse` at window index 975, and it applies to the whole following window. Changes at any other time do not affect the requests.
- R8: The value -128 is applied as magnitude 127 in the slowing direction. The largest magnitude is 127.
- R9: An applied value of zero gives no request in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock that also drives the prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| corr_val | input | 8 | Signed correction value, two's complement |
| roll_pulse | input | 1 | One-cycle pulse on each prescaler rollover |
| step_double | output | 1 | Request that the prescaler advance by 2 in this cycle |
| step_hold | output | 1 | Request that the prescaler advance by 0 in this cycle |
| win_idx | output | 10 | Index of the next period within the 976-period window |

## Verification
The bench checks the window boundary. If the value were latched at the wrong pulse, or latched continuously, the mid-window changes to `corr_val` would show up as extra or missing requests. It checks that the last period of each window fires for every nonzero magnitude. An accumulator that wrapped at 975 or 977 would drift and miss that request, or add one, and the count for that window would be wrong. It also runs magnitude 127 in both directions and the value -128. A naive negation of -128 would yield zero or a wrong-signed magnitude, and the request count would be off.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int CORR_W = 8;
  localparam int MAG_W  = CORR_W - 1;
  localparam int WINDOW = 976;

  // Magnitude of a signed correction, most negative code clamped to the max.
  function automatic logic [MAG_W-1:0] corr_mag(input logic [CORR_W-1:0] v);
    logic [CORR_W-1:0] neg;
    if (!v[CORR_W-1]) return v[MAG_W-1:0];
    neg = ~v + 1'b1;
    if (neg[CORR_W-1]) return {MAG_W{1'b1}};
    return neg[MAG_W-1:0];
  endfunction

  // True when this value asks for a slower count (cycles added).
  function automatic logic corr_slow(input logic [CORR_W-1:0] v);
    return v[CORR_W-1];
  endfunction
endpackage

// File: rtl/ftc_window_ctr.sv
module ftc_window_ctr #(
  parameter int PERIODS = 976,
  parameter int IDX_W   = $clog2(PERIODS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PERIODS - 1);

  assign last = step && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (last) idx <= '0;
    else if (step) idx <= idx + 1'b1;
  end

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(idx));
  // R2
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx == LAST_IDX) |=> (idx == '0));
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);
endmodule

// File: rtl/ftc_accum.sv
module ftc_accum #(
  parameter int PERIODS = 976,
  parameter int MAG_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic [MAG_W-1:0] mag,
  output logic             fire
);
  localparam int ACC_W = $clog2(PERIODS);
  localparam int SUM_W = ACC_W + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(PERIODS);

  logic [ACC_W-1:0] acc;
  logic [SUM_W-1:0] sum;

  assign sum  = {1'b0, acc} + {{(SUM_W-MAG_W){1'b0}}, mag};
  assign fire = step && (sum >= LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n || (step && clear)) acc <= '0;
    else if (fire)                 acc <= ACC_W'(sum - LIMIT);
    else if (step)                 acc <= sum[ACC_W-1:0];
  end

  // R6
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, acc} < LIMIT);
  // R9
  zero_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mag == '0) |-> !fire);
endmodule

// File: rtl/freq_trim_corrector.sv
module freq_trim_corrector #(
  parameter int PERIODS = ftc_pkg::WINDOW,
  parameter int IDX_W   = $clog2(PERIODS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ftc_pkg::CORR_W-1:0] corr_val,
  input  logic                       roll_pulse,
  output logic                       step_double,
  output logic                       step_hold,
  output logic [IDX_W-1:0]           win_idx
);
  import ftc_pkg::*;

  logic [CORR_W-1:0] active_val;
  logic [MAG_W-1:0]  active_mag;
  logic              win_last;
  logic              adj_fire;

  assign active_mag = corr_mag(active_val);

  ftc_window_ctr #(.PERIODS(PERIODS), .IDX_W(IDX_W)) u_win (
    .clk(clk), .rst_n(rst_n), .step(roll_pulse),
    .idx(win_idx), .last(win_last)
  );

  ftc_accum #(.PERIODS(PERIODS), .MAG_W(MAG_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(roll_pulse), .clear(win_last),
    .mag(active_mag), .fire(adj_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        active_val <= '0;
    else if (win_last) active_val <= corr_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_double <= 1'b0;
      step_hold   <= 1'b0;
    end else begin
      step_double <= adj_fire && !corr_slow(active_val);
      step_hold   <= adj_fire &&  corr_slow(active_val);
    end
  end

  // R4
  no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_double && step_hold));
  // R3
  req_after_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_double || step_hold) |-> $past(roll_pulse));
  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_double || step_hold) |=> !(step_double || step_hold));
  // R7
  latch_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_last |=> $stable(active_val));
endmodule

// File: tb/sim_freq_trim_corrector.sv
`timescale 1ns/1ps
module sim_freq_trim_corrector;
  localparam int WIN = 976;
  localparam int NV  = 6;
  localparam logic [7:0] VALS [NV] = '{8'h05, 8'hFD, 8'h7F, 8'h80, 8'h00, 8'h01};
  localparam int EXP_CNT [NV]      = '{5, 3, 127, 127, 0, 1};
  localparam bit EXP_SLOW [NV]     = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] corr_val = 8'h00;
  logic roll_pulse = 1'b0;
  logic step_double, step_hold;
  logic [9:0] win_idx;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  freq_trim_corrector u0 (
    .clk(clk), .rst_n(rst_n), .corr_val(corr_val), .roll_pulse(roll_pulse),
    .step_double(step_double), .step_hold(step_hold), .win_idx(win_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_fire(input int k, input int m);
    return ((k + 1) * m) / WIN != (k * m) / WIN;
  endfunction

  // Runs one window; applied magnitude m, direction slow; returns request count.
  task automatic run_window(input int m, input bit slow, input logic [7:0] next_val,
                            output int cnt);
    cnt = 0;
    corr_val = ~next_val;
    for (int k = 0; k < WIN; k++) begin
      if (k == WIN - 3) corr_val = next_val;
      roll_pulse = 1'b1;
      @(negedge clk);
      roll_pulse = 1'b0;
      // R2: index advanced after pulse
      chk(win_idx == 10'((k + 1) % WIN), "R2 idx", int'(win_idx), (k + 1) % WIN);
      // R4
      chk(!(step_double && step_hold), "R4 both", int'(step_double), 0);
      // R6 R5 R7: request vs independent model
      chk(step_double == (exp_fire(k, m) && !slow), "R6/R5 double",
          int'(step_double), int'(exp_fire(k, m) && !slow));
      chk(step_hold == (exp_fire(k, m) && slow), "R6/R5 hold",
          int'(step_hold), int'(exp_fire(k, m) && slow));
      if (step_double || step_hold) cnt++;
      @(negedge clk);
      // R3: no request in the idle cycle, index held
      chk(!step_double && !step_hold, "R3 idle", int'(step_double | step_hold), 0);
      chk(win_idx == 10'((k + 1) % WIN), "R2 hold", int'(win_idx), (k + 1) % WIN);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    int pm;
    bit ps;
    repeat (3) @(negedge clk);
    // R1
    chk(!step_double && !step_hold && win_idx == 0, "R1 reset", int'(win_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!step_double && !step_hold && win_idx == 0, "R1 idle", int'(win_idx), 0);

    // R1: first window applies zero
    pm = 0; ps = 1'b0;
    for (int i = 0; i < NV; i++) begin
      run_window(pm, ps, VALS[i], cnt);
      chk(cnt == pm, "R6 count", cnt, pm);
      pm = EXP_CNT[i];
      ps = EXP_SLOW[i];
    end
    // last entry (value 1) applied here; R8 and R9 covered by table entries 0x80 and 0x00
    run_window(pm, ps, 8'h00, cnt);
    chk(cnt == 1, "R6 count last", cnt, 1);

    // R8 directed: -128 gives 127 holds
    run_window(0, 1'b0, 8'h80, cnt);
    chk(cnt == 0, "R9 zero window", cnt, 0);
    run_window(127, 1'b1, 8'h00, cnt);
    chk(cnt == 127, "R8 clamp count", cnt, 127);

    // R1: reset mid-window clears index
    roll_pulse = 1'b1; @(negedge clk); roll_pulse = 1'b0;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(win_idx == 0 && !step_double && !step_hold, "R1 re-reset", int'(win_idx), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule